// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the input pins of a general-purpose I/O controller and records interrupt events. On every clock edge it compares each pin's already-synchronised level with the level it held one cycle earlier. It then sets that pin's bit in a sticky status vector when the pin's selected trigger condition is met. Each pin picks one of four triggers with a 2-bit code: low level, high level, rising edge or falling edge. A per-pin any-edge select overrides the code and fires on every change of level. Pins configured as outputs never raise events.

Status bits stay set until the register bank pulses the matching clear bit. Because the trigger conditions are evaluated every cycle, changes to configuration and clears take effect at once. A level condition that still holds sets its bit again at the same edge that would clear it. A mask vector gates the status onto the request outputs. The outputs are either one line for all pins, or two lines that cover the lower and upper halves of the pins. There is no streaming data path, so every pin is a plain level-valued control or status signal with no valid/ready handshake.

Top module: `gpio_irq_detect`

## Requirements
- R1: With direction bit 0 (input), no any-edge select and code 2'b00 in `cond_i[2n+1:2n]`, pin n sets `status_o[n]` at every edge where its level is 0.
- R2: With code 2'b01, pin n sets `status_o[n]` at every edge where its level is 1.
- R3: With code 2'b10, pin n sets `status_o[n]` only at an edge where its level is 1 and its level at the previous edge was 0.
- R4: With code 2'b11, pin n sets `status_o[n]` only at an edge where its level is 0 and its level at the previous edge was 1.
- R5: When `anyedge_i[n]` is 1, any difference between pin n's level and its previous level sets `status_o[n]`, and the 2-bit code of that pin has no effect.
- R6: A pin whose `dir_i` bit is 1 (output) never sets its status bit.
- R7: A status bit that is set stays set until an edge at which its `clr_i` bit is 1, and then reads 0 after that edge.
- R8: When a clear and a detection hit the same bit at the same edge, the bit is 1 after that edge.
- R9: A change of direction, code or any-edge select takes effect at the next edge: a level condition that becomes true against the current pin level sets its bit there.
- R10: With SPLIT=1, `irq_o[0]` is the OR of `status_o & mask_i` over bits 15..0 and `irq_o[1]` is that OR over bits 31..16. With SPLIT=0, `irq_o[0]` covers all bits and `irq_o[1]` is 0. Both outputs follow `mask_i` combinationally.
- R11: While `rst_n` is 0, `status_o` and `irq_o` are 0 and the stored previous levels are 0, so a pin that is high at the first edge after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | 32 | Synchronised pin levels |
| dir_i | input | 32 | Per-pin direction, 1 = output |
| cond_i | input | 64 | Per-pin 2-bit trigger code, pin n at bits 2n+1:2n |
| anyedge_i | input | 32 | Per-pin any-edge override |
| mask_i | input | 32 | Per-pin request enable |
| clr_i | input | 32 | Per-pin clear pulse for status |
| status_o | output | 32 | Sticky event status |
| irq_o | output | 2 | Request lines (lower/upper halves, or one combined line on bit 0) |

## Verification
A pin level, a configuration value or a clear that is presented before a rising edge shows up in `status_o` right after that edge, because one register lies on the path. The request lines have no register of their own: they follow `status_o` at the same edge, and they follow a change of `mask_i` within the same cycle. The bench changes inputs on the falling edge and compares outputs at the following falling edge, so every result is observed exactly one edge after its cause. Directed sequences set up each trigger code, the override, the clear priority and the output-pin case against literal expected vectors. A random phase then compares every cycle against a bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  // Code bit 1 picks edge vs level; bit 0 is the level that fires (level
  // mode) or the level that must be left behind (edge mode).
  function automatic logic trig_match(input trig_e code, input logic now,
                                      input logic was);
    logic moved;
    moved = now ^ was;
    if (code[1]) trig_match = moved && (now != code[0]);
    else         trig_match = (now == code[0]);
  endfunction

endpackage

// File: rtl/pin_trig_eval.sv
module pin_trig_eval
  import gpio_irq_pkg::*;
#(
  parameter bit ANY_EDGE_EN = 1'b1
) (
  input  logic       level_i,
  input  logic       last_i,
  input  logic [1:0] code_i,
  input  logic       any_sel_i,
  input  logic       is_out_i,
  output logic       hit_o
);

  logic coded_hit;

  always_comb coded_hit = trig_match(trig_e'(code_i), level_i, last_i);

  generate
    if (ANY_EDGE_EN) begin : g_any
      logic sel_hit;
      always_comb sel_hit = any_sel_i ? (level_i ^ last_i) : coded_hit;
      assign hit_o = sel_hit && !is_out_i;
    end else begin : g_plain
      logic unused_sel;
      assign unused_sel = any_sel_i;
      assign hit_o = coded_hit && !is_out_i;
    end
  endgenerate

endmodule

// File: rtl/level_history.sv
module level_history #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] level_i,
  output logic [NPIN-1:0] last_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_o <= '0;
    else        last_o <= level_i;
  end

endmodule

// File: rtl/event_status.sv
module event_status #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] hit_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] status_o
);

  logic [NPIN-1:0] status_d;

  // A hit wins over a clear in the same cycle so no event is dropped.
  always_comb status_d = (status_o & ~clr_i) | hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= status_d;
  end

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NPIN  = 32,
  parameter bit SPLIT = 1'b1
) (
  input  logic [NPIN-1:0] status_i,
  input  logic [NPIN-1:0] mask_i,
  output logic [1:0]      irq_o
);

  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0] armed;
  always_comb armed = status_i & mask_i;

  generate
    if (SPLIT) begin : g_split
      assign irq_o[0] = |armed[HALF-1:0];
      assign irq_o[1] = |armed[NPIN-1:HALF];
    end else begin : g_single
      assign irq_o[0] = |armed;
      assign irq_o[1] = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPIN        = 32,
  parameter bit SPLIT       = 1'b1,
  parameter bit ANY_EDGE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pad_i,
  input  logic [NPIN-1:0]   dir_i,
  input  logic [2*NPIN-1:0] cond_i,
  input  logic [NPIN-1:0]   anyedge_i,
  input  logic [NPIN-1:0]   mask_i,
  input  logic [NPIN-1:0]   clr_i,
  output logic [NPIN-1:0]   status_o,
  output logic [1:0]        irq_o
);

  logic [NPIN-1:0] last_lvl;
  logic [NPIN-1:0] hit;

  level_history #(.NPIN(NPIN)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pad_i),
    .last_o  (last_lvl)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    pin_trig_eval #(.ANY_EDGE_EN(ANY_EDGE_EN)) u_eval (
      .level_i   (pad_i[p]),
      .last_i    (last_lvl[p]),
      .code_i    (cond_i[2*p+1:2*p]),
      .any_sel_i (anyedge_i[p]),
      .is_out_i  (dir_i[p]),
      .hit_o     (hit[p])
    );
  end

  event_status #(.NPIN(NPIN)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit),
    .clr_i    (clr_i),
    .status_o (status_o)
  );

  irq_merge #(.NPIN(NPIN), .SPLIT(SPLIT)) u_irq (
    .status_i (status_o),
    .mask_i   (mask_i),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPIN  = 32,
  parameter bit SPLIT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPIN-1:0]   pad_i,
  input logic [NPIN-1:0]   dir_i,
  input logic [2*NPIN-1:0] cond_i,
  input logic [NPIN-1:0]   anyedge_i,
  input logic [NPIN-1:0]   mask_i,
  input logic [NPIN-1:0]   clr_i,
  input logic [NPIN-1:0]   status_o,
  input logic [1:0]        irq_o
);

  localparam int HALF = NPIN / 2;

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ($past(status_o) & ~$past(clr_i))) ==
              ($past(status_o) & ~$past(clr_i))));

  a_r6_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~($past(status_o) & ~$past(clr_i)) & $past(dir_i)) == '0));

  a_r11_reset: assert property (@(posedge clk)
    !rst_n |-> (status_o == '0 && irq_o == 2'b00));

  generate
    if (SPLIT) begin : g_split_chk
      a_r10_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] == |(status_o[HALF-1:0] & mask_i[HALF-1:0]));
      a_r10_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] == |(status_o[NPIN-1:HALF] & mask_i[NPIN-1:HALF]));
    end else begin : g_single_chk
      a_r10_irq_all: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == {1'b0, |(status_o & mask_i)});
    end
  endgenerate

  for (genvar p = 0; p < NPIN; p++) begin : g_pin_chk
    // R3: a rise-coded pin may only newly set on a high level
    a_r3_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[p] && !($past(status_o[p]) && !$past(clr_i[p])) &&
       !$past(anyedge_i[p]) && $past(cond_i[2*p+1:2*p]) == 2'b10)
      |-> $past(pad_i[p]));
    // R4: a fall-coded pin may only newly set on a low level
    a_r4_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[p] && !($past(status_o[p]) && !$past(clr_i[p])) &&
       !$past(anyedge_i[p]) && $past(cond_i[2*p+1:2*p]) == 2'b11)
      |-> !$past(pad_i[p]));
  end

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPIN(NPIN), .SPLIT(SPLIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pad_i     (pad_i),
  .dir_i     (dir_i),
  .cond_i    (cond_i),
  .anyedge_i (anyedge_i),
  .mask_i    (mask_i),
  .clr_i     (clr_i),
  .status_o  (status_o),
  .irq_o     (irq_o)
);

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pad = '0, dir = '1, anyedge = '0, mask = '0, clr = '0;
  logic [63:0] cond = '0;
  logic [31:0] status;
  logic [1:0]  irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] m_status = '0;
  logic [31:0] m_prev   = '0;

  always #2.5 clk = ~clk;

  gpio_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .dir_i(dir), .cond_i(cond),
    .anyedge_i(anyedge), .mask_i(mask), .clr_i(clr),
    .status_o(status), .irq_o(irq)
  );

  function automatic logic pin_fires(logic now, logic was, logic [1:0] code,
                                     logic any, logic out);
    if (out) return 1'b0;
    if (any) return now != was;
    if (code == 2'b00) return !now;
    if (code == 2'b01) return now;
    if (code == 2'b10) return now && !was;
    return !now && was;
  endfunction

  function automatic logic [1:0] irq_of(logic [31:0] s, logic [31:0] m);
    return {|(s[31:16] & m[31:16]), |(s[15:0] & m[15:0])};
  endfunction

  task automatic step();
    logic [31:0] fire;
    @(posedge clk);
    for (int i = 0; i < 32; i++)
      fire[i] = pin_fires(pad[i], m_prev[i], cond[2*i +: 2], anyedge[i], dir[i]);
    m_status = (m_status & ~clr) | fire;
    m_prev   = pad;
    @(negedge clk);
  endtask

  task automatic cmp(string req, logic [31:0] exp_s);
    logic [1:0] exp_i;
    exp_i = irq_of(exp_s, mask);
    vectors++;
    if (status !== exp_s || irq !== exp_i) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               req, status, irq, exp_s, exp_i);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    cmp("R11", 32'h0);
    rst_n = 1'b1;
    // R6: outputs only, everything cleared
    clr = '1; pad = 32'hFFFF_0000; step(); cmp("R6", 32'h0);
    clr = '0; pad = 32'h0000_FFFF; step(); cmp("R6", 32'h0);
    // R1: low level on all pins
    dir = '0; cond = '0; pad = '0; step(); cmp("R1", 32'hFFFF_FFFF);
    // R7: sticky, then partial clear
    dir = '1; pad = 32'h1357_9BDF; step(); cmp("R7", 32'hFFFF_FFFF);
    clr = 32'h0000_FFFF; mask = 32'h0001_0000; step(); cmp("R7", 32'hFFFF_0000);
    // R10: mask gates request halves at once
    vectors++;
    if (irq !== 2'b10) begin errors++; $display("FAIL R10: irq=%b expected 10", irq); end
    clr = '0; mask = 32'h0000_0001; #1;
    vectors++;
    if (irq !== 2'b00) begin errors++; $display("FAIL R10: irq=%b expected 00", irq); end
    // R2: high level
    clr = '1; step(); cmp("R7", 32'h0);
    clr = '0; cond = {32{2'b01}}; pad = 32'hA5A5_0F0F; dir = '0; step();
    cmp("R2", 32'hA5A5_0F0F);
    // R3: rising edge only
    cond = {32{2'b10}}; pad = '0; clr = '1; step(); cmp("R3", 32'h0);
    clr = '0; pad = 32'h0000_00FF; step(); cmp("R3", 32'h0000_00FF);
    pad = '0; step(); cmp("R3", 32'h0000_00FF);
    // R4: falling edge only
    cond = {32{2'b11}}; clr = '1; step(); cmp("R4", 32'h0);
    clr = '0; pad = 32'h0F00_0000; step(); cmp("R4", 32'h0);
    pad = '0; step(); cmp("R4", 32'h0F00_0000);
    // R5: any-edge overrides a low-level code while the pin sits low
    cond = '0; anyedge = '1; clr = '1; step(); cmp("R5", 32'h0);
    clr = '0; pad = 32'h0000_0001; step(); cmp("R5", 32'h0000_0001);
    // R8: clear and fall in the same cycle: detection wins
    pad = '0; clr = '1; step(); cmp("R8", 32'h0000_0001);
    // R8: level condition still holding survives a clear
    anyedge = '0; clr = '1; step(); cmp("R8", 32'hFFFF_FFFF);
    // R9: code change re-evaluated against current level
    cond = {32{2'b01}}; step(); cmp("R9", 32'h0);
    clr = '0; cond = '0; step(); cmp("R9", 32'hFFFF_FFFF);
    // R6: turning pins into outputs stops level re-setting after clear
    dir = 32'hFFFF_0000; clr = '1; step(); cmp("R6", 32'h0000_FFFF);
    // random phase against the model (R1..R10)
    for (int n = 0; n < 3000; n++) begin
      pad     = $urandom;
      dir     = $urandom & $urandom;
      cond    = {$urandom, $urandom};
      anyedge = $urandom & $urandom;
      mask    = $urandom;
      clr     = $urandom & $urandom & $urandom;
      step();
      cmp("R1-R10 random", m_status);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule